// File: doc/BRIEF.md
# Programmable Sync Pulse Generator

This block produces the synchronisation strobes for a signal-processing datapath. It accepts two external sync inputs, A and B. Each input is also passed through its own programmable delay line, which forms the delayed syncs DA and DB. A free-running 20-bit period counter raises a terminal-count strobe once per period. The period is sixteen times one more than a 16-bit programmed value. A one-cycle software pulse from the register side is a further source.

Six independent selectors each choose one of these sources, or none. The outputs are registered. Index 0 of the output vector is the counter's own sync and restarts the counter at zero. Indices 1 to 4 go to the symbol-alignment, capture, loop-filter and oscillator consumers. Index 5 is the sync pin that leaves the chip. The low twelve counter bits are brought out for diagnostics.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst` is high, at every clock edge all bits of `sync_o` clear to 0, the counter clears to 0, `diag_o` reads 0 and `tc_o` reads 0.
- R2: With no resync, the counter steps by one each clock from 0 up to 16*(P+1)-1, where P is `period_i`, and then returns to 0. `diag_o` shows the low 12 bits of the counter.
- R3: `tc_o` is high for exactly one clock, on the clock when the counter holds 16*(P+1)-1. Consecutive pulses are 16*(P+1) clocks apart.
- R4: When `sync_o[0]` is high, the counter holds 0 on the next clock.
- R5: A delay setting N from 1 to 258 makes the delayed sync equal to its input N clocks earlier.
- R6: A delay setting of 0 passes the input through with no added delay. A setting above 258 behaves as 258.
- R7: Selector i occupies bits `sel_i[3*i+2:3*i]`. The codes are 1 = A, 2 = B, 3 = DA, 4 = DB and 5 = terminal count. `sync_o[i]` is the chosen source as it was one clock earlier.
- R8: Selector codes 0 (free run) and 7 (reserved) keep `sync_o[i]` low.
- R9: The six selectors act independently. Output index 0 restarts the counter, indices 1 to 4 feed the alignment, capture, loop and oscillator consumers, and index 5 is the external sync output.
- R10: Code 6 selects `oneshot_i`, which then appears on `sync_o[i]` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_a_i | input | 1 | External sync input A |
| sync_b_i | input | 1 | External sync input B |
| oneshot_i | input | 1 | Single-cycle software sync pulse |
| dly_a_i | input | 9 | Delay setting for input A in clocks (values above 258 act as 258) |
| dly_b_i | input | 9 | Delay setting for input B in clocks (values above 258 act as 258) |
| period_i | input | 16 | Period value P; the counter period is 16*(P+1) clocks |
| sel_i | input | 18 | Six 3-bit source selectors; selector i is bits [3i+2:3i] |
| sync_o | output | 6 | Registered selected syncs; index 0 is the counter resync, 1..4 go to the internal consumers, 5 is the external sync |
| tc_o | output | 1 | Terminal-count pulse |
| diag_o | output | 12 | Low 12 bits of the period counter |

## Verification
Every selector code is tried with one shared pattern on A, B and the one-shot. In that pattern the three inputs have different bit patterns, so a wrong source mapping changes the output. The delay settings swept are 0, 1, 2, 7, 258, 259 and 511, with single isolated pulses, so an off-by-one delay and a missing clamp each give a visibly wrong latency. A mixed configuration gives each output index a different code, which exposes crossed selector fields. Counter restarts are checked at periods of 16, 32, 64 and 4816 clocks; the longest period also shows the 12-bit wrap of the diagnostic output within a single period.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int SEL_W   = 3;
    localparam int NUM_SEL = 6;
    localparam int PER_W   = 16;
    localparam int CNT_W   = 20;
    localparam int DLY_W   = 9;
    localparam int MAX_DLY = 258;
    localparam int DIAG_W  = 12;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_A    = 3'd1,
        SRC_B    = 3'd2,
        SRC_DA   = 3'd3,
        SRC_DB   = 3'd4,
        SRC_TC   = 3'd5,
        SRC_OS   = 3'd6,
        SRC_RSV  = 3'd7
    } sync_src_e;

    typedef struct packed {
        logic os;
        logic tc;
        logic db;
        logic da;
        logic b;
        logic a;
    } sync_bus_t;

    function automatic logic pick_src(input sync_src_e code, input sync_bus_t s);
        case (code)
            SRC_A:   return s.a;
            SRC_B:   return s.b;
            SRC_DA:  return s.da;
            SRC_DB:  return s.db;
            SRC_TC:  return s.tc;
            SRC_OS:  return s.os;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
    parameter int MAX_DLY = 258,
    parameter int DLY_W   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             out_o
);
    localparam logic [DLY_W-1:0] DLY_CAP = DLY_W'(MAX_DLY);

    logic [MAX_DLY-1:0] tap_q;
    logic [DLY_W-1:0]   dly_eff;
    logic               past_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q     <= '0;
            past_ok_q <= 1'b0;
        end else begin
            tap_q     <= {tap_q[MAX_DLY-2:0], in_i};
            past_ok_q <= 1'b1;
        end
    end

    assign dly_eff = (dly_i > DLY_CAP) ? DLY_CAP : dly_i;

    always_comb begin
        out_o = in_i;
        for (int k = 1; k <= MAX_DLY; k++) begin
            if (dly_eff == DLY_W'(k)) out_o = tap_q[k-1];
        end
    end

    // R5
    dly_one_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && dly_i == DLY_W'(1)) |-> (out_o == $past(in_i)));

    // R6
    dly_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && dly_i > DLY_CAP) |-> (out_o == tap_q[MAX_DLY-1]));

endmodule

// File: rtl/sync_period_counter.sv
module sync_period_counter #(
    parameter int PER_W = 16,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resync_i,
    input  logic [PER_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o
);
    localparam int SUB_W = CNT_W - PER_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = {period_i, {SUB_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (resync_i)      cnt_q <= '0;
        else if (cnt_q >= limit) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign tc_o  = (cnt_q == limit);

    // R3
    tc_single_chk: assert property (@(posedge clk) disable iff (rst)
        tc_o |=> !tc_o);

    // R4
    resync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (cnt_q == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!resync_i && !tc_o && cnt_q < limit) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sync_source_mux.sv
module sync_source_mux
    import sync_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel_i,
    input  sync_bus_t  src_i,
    output logic       sync_o
);
    sync_src_e code;
    logic      sync_q;

    assign code = sync_src_e'(sel_i);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= pick_src(code, src_i);
    end

    assign sync_o = sync_q;

    // R8
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (code == SRC_NONE || code == SRC_RSV) |=> !sync_q);

    // R10
    os_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (code == SRC_OS && src_i.os) |=> sync_q);

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_gen_pkg::*;
#(
    parameter int NUM_SEL_P = NUM_SEL,
    parameter int MAX_DLY_P = MAX_DLY,
    parameter int DLY_W_P   = DLY_W,
    parameter int PER_W_P   = PER_W,
    parameter int CNT_W_P   = CNT_W,
    parameter int DIAG_W_P  = DIAG_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sync_a_i,
    input  logic                         sync_b_i,
    input  logic                         oneshot_i,
    input  logic [DLY_W_P-1:0]           dly_a_i,
    input  logic [DLY_W_P-1:0]           dly_b_i,
    input  logic [PER_W_P-1:0]           period_i,
    input  logic [NUM_SEL_P*SEL_W-1:0]   sel_i,
    output logic [NUM_SEL_P-1:0]         sync_o,
    output logic                         tc_o,
    output logic [DIAG_W_P-1:0]          diag_o
);
    localparam int RESYNC_IDX = 0;

    sync_bus_t          srcs;
    logic               da, db, tc;
    logic [CNT_W_P-1:0] cnt;

    sync_delay_line #(.MAX_DLY(MAX_DLY_P), .DLY_W(DLY_W_P)) u_dly_a (
        .clk(clk), .rst(rst), .in_i(sync_a_i), .dly_i(dly_a_i), .out_o(da)
    );

    sync_delay_line #(.MAX_DLY(MAX_DLY_P), .DLY_W(DLY_W_P)) u_dly_b (
        .clk(clk), .rst(rst), .in_i(sync_b_i), .dly_i(dly_b_i), .out_o(db)
    );

    sync_period_counter #(.PER_W(PER_W_P), .CNT_W(CNT_W_P)) u_cnt (
        .clk(clk), .rst(rst), .resync_i(sync_o[RESYNC_IDX]),
        .period_i(period_i), .cnt_o(cnt), .tc_o(tc)
    );

    always_comb begin
        srcs.a  = sync_a_i;
        srcs.b  = sync_b_i;
        srcs.da = da;
        srcs.db = db;
        srcs.tc = tc;
        srcs.os = oneshot_i;
    end

    for (genvar i = 0; i < NUM_SEL_P; i++) begin : g_sel
        sync_source_mux u_mux (
            .clk(clk), .rst(rst),
            .sel_i(sel_i[i*SEL_W +: SEL_W]),
            .src_i(srcs),
            .sync_o(sync_o[i])
        );
    end

    assign tc_o   = tc;
    assign diag_o = cnt[DIAG_W_P-1:0];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (sync_o == '0 && diag_o == '0));

endmodule

// File: tb/sync_pulse_gen_tb.sv
module sync_pulse_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sync_a_i, sync_b_i, oneshot_i;
    logic [8:0]  dly_a_i, dly_b_i;
    logic [15:0] period_i;
    logic [17:0] sel_i;
    logic [5:0]  sync_o;
    logic        tc_o;
    logic [11:0] diag_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit r9_mode = 0;

    logic ah [0:511];
    logic bh [0:511];
    logic oh [0:511];
    logic tc_pre;

    always #5 clk = ~clk;

    sync_pulse_gen u_dut (
        .clk(clk), .rst(rst), .sync_a_i(sync_a_i), .sync_b_i(sync_b_i),
        .oneshot_i(oneshot_i), .dly_a_i(dly_a_i), .dly_b_i(dly_b_i),
        .period_i(period_i), .sel_i(sel_i), .sync_o(sync_o),
        .tc_o(tc_o), .diag_o(diag_o)
    );

    function automatic int deff(input logic [8:0] d);
        return (d > 9'd258) ? 258 : int'(d);
    endfunction

    function automatic string tag_of(input int code);
        if (r9_mode) return "R9";
        case (code)
            0, 7:    return "R8";
            3, 4:    return "R5/R6";
            6:       return "R10";
            default: return "R7";
        endcase
    endfunction

    function automatic logic exp_src(input int code);
        case (code)
            1: return ah[0];
            2: return bh[0];
            3: return ah[deff(dly_a_i)];
            4: return bh[deff(dly_b_i)];
            5: return tc_pre;
            6: return oh[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a negedge: drives inputs, lets one edge pass, checks selectors.
    task automatic step(input logic na, input logic nb, input logic nos, input bit chk);
        sync_a_i  = na;
        sync_b_i  = nb;
        oneshot_i = nos;
        for (int k = 511; k > 0; k--) begin
            ah[k] = ah[k-1];
            bh[k] = bh[k-1];
            oh[k] = oh[k-1];
        end
        ah[0] = na;
        bh[0] = nb;
        oh[0] = nos;
        #4;
        tc_pre = tc_o;
        @(negedge clk);
        if (chk) begin
            for (int i = 0; i < 6; i++) begin
                int code;
                logic e;
                code = int'(sel_i[i*3 +: 3]);
                e = exp_src(code);
                check(sync_o[i] == e, tag_of(code), int'(sync_o[i]), int'(e));
            end
        end
    endtask

    task automatic set_all(input logic [2:0] c);
        sel_i = {6{c}};
    endtask

    task automatic cnt_test(input int c);
        int p;
        p = 16 * (c + 1);
        period_i = 16'(c);
        sel_i = {15'd0, 3'd1};
        step(1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        // R4: restart seen as zero two samples after the pulse
        check(diag_o == 12'd0, "R4", int'(diag_o), 0);
        for (int k = 1; k <= p + 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0);
            // R2
            check(diag_o == 12'((k % p) & 'hFFF), "R2", int'(diag_o), (k % p) & 'hFFF);
            // R3
            check(tc_o == ((k % p) == p - 1), "R3", int'(tc_o), int'((k % p) == p - 1));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int dl [7] = '{0, 1, 2, 7, 258, 259, 511};
        for (int k = 0; k < 512; k++) begin
            ah[k] = 1'b0; bh[k] = 1'b0; oh[k] = 1'b0;
        end
        rst = 1'b1;
        sync_a_i = 0; sync_b_i = 0; oneshot_i = 0;
        dly_a_i = 9'd0; dly_b_i = 9'd0; period_i = 16'd0;
        sel_i = '0;
        @(negedge clk);
        // R1: drive every selector to A and pulse inputs during reset
        set_all(3'd1);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 1'b0);
        check(sync_o == 6'd0, "R1", int'(sync_o), 0);
        check(diag_o == 12'd0, "R1", int'(diag_o), 0);
        check(tc_o == 1'b0, "R1", int'(tc_o), 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // R7 R8 R10: every code on every selector, mixed input pattern
        dly_a_i = 9'd2;
        dly_b_i = 9'd0;
        for (int c = 0; c < 8; c++) begin
            set_all(3'(c));
            for (int i = 0; i < 40; i++)
                step(1'(i), 1'((i >> 1) ^ (i >> 2)), 1'(i % 5 == 0), 1'b1);
        end

        // R5 R6: delay sweep with isolated pulses
        sel_i = {3'd4, 3'd3, 3'd4, 3'd3, 3'd4, 3'd0};
        foreach (dl[j]) begin
            dly_a_i = 9'(dl[j]);
            dly_b_i = (dl[j] == 0) ? 9'd1 : 9'(dl[j] - 1);
            step(1'b1, 1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b1, 1'b0, 1'b1);
            for (int i = 0; i < 530; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        end

        // R9: each output index on a different source
        r9_mode = 1;
        dly_a_i = 9'd4;
        dly_b_i = 9'd9;
        period_i = 16'd0;
        sel_i = {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd7};
        for (int i = 0; i < 80; i++)
            step(1'(i % 3 == 0), 1'(i % 7 == 1), 1'(i % 11 == 2), 1'b1);
        r9_mode = 0;

        // R2 R3 R4: counter periods and restart
        cnt_test(0);
        cnt_test(1);
        cnt_test(3);
        cnt_test(300);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule